// File: doc/BRIEF.md
# Deferred-Fault Register Datapath

This block is the register file and integer datapath of a core that lets the compiler hoist loads above the guards that protect them. Every architectural register carries a one-bit taint marker next to its data. A load flagged as speculative that meets a memory fault does not stop the machine. It taints its destination. Every arithmetic result computed from a tainted operand is tainted in turn. The fault becomes architecturally visible only when a check instruction finds a tainted register. At that point the block asks the front end to branch to the recovery address carried by the check.

A load issued without the speculative flag keeps ordinary behaviour: a fault raises an immediate trap, and its destination is left untouched. Tainted registers always hold zero data, so the wrong-path values are deterministic. Register 0 is a hard zero. One instruction is accepted per clock. A third read port lets the surrounding logic observe any register and its marker.

Top module: `dfd_core`

## Requirements
- R1: While rst_n is low and after its release, every register reads data 0 with its marker clear, and redirect_valid, redirect_target and trap_valid are 0.
- R2: Opcodes are 0 NOP, 1 ADD, 2 SUB, 3 AND, 4 XOR, 5 LOAD, 6 CHECK, 7 MOVI. An accepted ADD/SUB/AND/XOR with both sources clean writes rs1 op rs2 (modulo 2^16) to rd and clears rd's marker. MOVI writes ins_imm clean. The result is visible on the view port in the cycle after the accepting edge.
- R3: A LOAD without a fault writes mem_data clean to rd, whatever ins_spec is. A LOAD with ins_spec=1 and mem_fault=1 writes data 0 with the marker set, and it raises neither trap_valid nor redirect_valid.
- R4: A LOAD with ins_spec=0 and mem_fault=1 drives trap_valid high for exactly the one cycle after the accepting edge and leaves rd unchanged.
- R5: An ADD/SUB/AND/XOR that reads any tainted source writes data 0 with the marker set in rd. It raises no trap and no redirect.
- R6: A CHECK whose rs1 is tainted drives redirect_valid high for exactly the cycle after the accepting edge, with redirect_target equal to that CHECK's ins_target. No register changes, and the marker stays set. At all other times redirect_target is 0.
- R7: A CHECK whose rs1 is clean raises no redirect, no trap and no register change.
- R8: Register 0 always reads 0 with a clear marker. Writes to it, including tainting loads, are dropped, and a CHECK of it never redirects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_op | input | 3 | Opcode (see R2) |
| ins_spec | input | 1 | Load is speculative |
| ins_rd | input | 3 | Destination register |
| ins_rs1 | input | 3 | First source, also the register a CHECK tests |
| ins_rs2 | input | 3 | Second source |
| ins_imm | input | 16 | Immediate for MOVI |
| ins_target | input | 16 | Recovery address of a CHECK |
| mem_data | input | 16 | Load return data |
| mem_fault | input | 1 | Load access faulted |
| view_sel | input | 3 | Register selected for observation |
| view_data | output | 16 | Data of the selected register |
| view_poison | output | 1 | Marker of the selected register |
| redirect_valid | output | 1 | Branch to recovery code |
| redirect_target | output | 16 | Recovery address |
| trap_valid | output | 1 | Immediate fault of a non-speculative load |

## Verification
On every cycle the assertions check several relations. A tainted register write leaves zero data and a set marker behind it. A clean write clears the marker and stores the value. A CHECK of a tainted register is followed by a redirect to its own target, and a CHECK of a clean one by silence. Non-speculative faults trap, and speculative faults never do. The assertions cannot show that taint actually flows through a chain of dependent operations, that it stays silent until the check, or that register 0 ignores writes. The bench shows these with directed chains and a long pseudo-random instruction stream, comparing every register each cycle against its behavioural model.

// File: rtl/dfd_pkg.sv
package dfd_pkg;

    localparam logic [2:0] OP_NOP  = 3'd0;
    localparam logic [2:0] OP_ADD  = 3'd1;
    localparam logic [2:0] OP_SUB  = 3'd2;
    localparam logic [2:0] OP_AND  = 3'd3;
    localparam logic [2:0] OP_XOR  = 3'd4;
    localparam logic [2:0] OP_LOAD = 3'd5;
    localparam logic [2:0] OP_CHK  = 3'd6;
    localparam logic [2:0] OP_MOVI = 3'd7;

endpackage

// File: rtl/dfd_regfile.sv
module dfd_regfile #(
    parameter int NREGS = 8,
    parameter int DW    = 16,
    parameter int NRP   = 3,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic                     wpoison,
    input  logic [NRP-1:0][IW-1:0]   ra,
    output logic [NRP-1:0][DW-1:0]   rdat,
    output logic [NRP-1:0]           rpois
);

    typedef struct packed {
        logic [NREGS-1:0][DW-1:0] data;
        logic [NREGS-1:0]         poison;
    } rf_t;

    rf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && (waddr != '0)) begin
            st_d.data[waddr]   = wdata;
            st_d.poison[waddr] = wpoison;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NRP; g++) begin : g_rd
        assign rdat[g]  = st_q.data[ra[g]];
        assign rpois[g] = st_q.poison[ra[g]];
    end

    // R5 / R3: a tainted write must leave zero data and a set marker
    a_r5_poison_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wpoison && (waddr != '0)) |=>
            (st_q.data[$past(waddr)] == '0) && st_q.poison[$past(waddr)]);

    // R2: a clean write stores its value and clears the marker
    a_r2_clean_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wpoison && (waddr != '0)) |=>
            (st_q.data[$past(waddr)] == $past(wdata)) && !st_q.poison[$past(waddr)]);

endmodule

// File: rtl/dfd_exec.sv
module dfd_exec
    import dfd_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = 3
) (
    input  logic          valid,
    input  logic [2:0]    op,
    input  logic          spec,
    input  logic          fault,
    input  logic [DW-1:0] ld_data,
    input  logic [DW-1:0] imm,
    input  logic [IW-1:0] rd,
    input  logic [DW-1:0] s1_data,
    input  logic          s1_poison,
    input  logic [DW-1:0] s2_data,
    input  logic          s2_poison,
    output logic          we,
    output logic [IW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic          wpoison,
    output logic          chk_hit,
    output logic          trap_hit
);

    logic [DW-1:0] res;

    always_comb begin
        we       = 1'b0;
        wpoison  = 1'b0;
        res      = '0;
        chk_hit  = 1'b0;
        trap_hit = 1'b0;
        if (valid) begin
            case (op)
                OP_ADD, OP_SUB, OP_AND, OP_XOR: begin
                    we      = 1'b1;
                    wpoison = s1_poison | s2_poison;
                    case (op)
                        OP_ADD:  res = s1_data + s2_data;
                        OP_SUB:  res = s1_data - s2_data;
                        OP_AND:  res = s1_data & s2_data;
                        default: res = s1_data ^ s2_data;
                    endcase
                end
                OP_LOAD: begin
                    if (fault) begin
                        if (spec) begin
                            we      = 1'b1;
                            wpoison = 1'b1;
                        end else begin
                            trap_hit = 1'b1;
                        end
                    end else begin
                        we  = 1'b1;
                        res = ld_data;
                    end
                end
                OP_CHK:  chk_hit = s1_poison;
                OP_MOVI: begin
                    we  = 1'b1;
                    res = imm;
                end
                default: ;
            endcase
        end
        wdata = wpoison ? '0 : res;
    end

    assign waddr = rd;

endmodule

// File: rtl/dfd_core.sv
module dfd_core
    import dfd_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int DW    = 16,
    parameter int TW    = 16,
    localparam int IW   = $clog2(NREGS),
    localparam int NRP  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_valid,
    input  logic [2:0]    ins_op,
    input  logic          ins_spec,
    input  logic [IW-1:0] ins_rd,
    input  logic [IW-1:0] ins_rs1,
    input  logic [IW-1:0] ins_rs2,
    input  logic [DW-1:0] ins_imm,
    input  logic [TW-1:0] ins_target,
    input  logic [DW-1:0] mem_data,
    input  logic          mem_fault,
    input  logic [IW-1:0] view_sel,
    output logic [DW-1:0] view_data,
    output logic          view_poison,
    output logic          redirect_valid,
    output logic [TW-1:0] redirect_target,
    output logic          trap_valid
);

    typedef struct packed {
        logic          redir;
        logic [TW-1:0] tgt;
        logic          trap;
    } out_t;

    out_t o_d, o_q;

    logic [NRP-1:0][IW-1:0] ra;
    logic [NRP-1:0][DW-1:0] rdat;
    logic [NRP-1:0]         rpois;
    logic                   we, wpoison, chk_hit, trap_hit;
    logic [IW-1:0]          waddr;
    logic [DW-1:0]          wdata;

    assign ra = {view_sel, ins_rs2, ins_rs1};

    dfd_regfile #(.NREGS(NREGS), .DW(DW), .NRP(NRP)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .wpoison (wpoison),
        .ra      (ra),
        .rdat    (rdat),
        .rpois   (rpois)
    );

    dfd_exec #(.DW(DW), .IW(IW)) u_ex (
        .valid     (ins_valid),
        .op        (ins_op),
        .spec      (ins_spec),
        .fault     (mem_fault),
        .ld_data   (mem_data),
        .imm       (ins_imm),
        .rd        (ins_rd),
        .s1_data   (rdat[0]),
        .s1_poison (rpois[0]),
        .s2_data   (rdat[1]),
        .s2_poison (rpois[1]),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .wpoison   (wpoison),
        .chk_hit   (chk_hit),
        .trap_hit  (trap_hit)
    );

    always_comb begin
        o_d       = '0;
        o_d.redir = chk_hit;
        o_d.tgt   = chk_hit ? ins_target : '0;
        o_d.trap  = trap_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign view_data       = rdat[2];
    assign view_poison     = rpois[2];
    assign redirect_valid  = o_q.redir;
    assign redirect_target = o_q.tgt;
    assign trap_valid      = o_q.trap;

    a_r6_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && (ins_op == OP_CHK) && rpois[0]) |=>
            redirect_valid && (redirect_target == $past(ins_target)));

    a_r7_clean_check: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && (ins_op == OP_CHK) && !rpois[0]) |=> !redirect_valid && !trap_valid);

    a_r4_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && (ins_op == OP_LOAD) && !ins_spec && mem_fault) |=>
            trap_valid && !redirect_valid);

    a_r3_spec_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && (ins_op == OP_LOAD) && ins_spec && mem_fault) |=>
            !trap_valid && !redirect_valid);

endmodule

// File: tb/sim_dfd_core.sv
`timescale 1ns/1ps
module sim_dfd_core;

    localparam int NR = 8;
    localparam int DW = 16;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ins_valid = 1'b0;
    logic [2:0]    ins_op = '0;
    logic          ins_spec = 1'b0;
    logic [2:0]    ins_rd = '0, ins_rs1 = '0, ins_rs2 = '0;
    logic [DW-1:0] ins_imm = '0;
    logic [TW-1:0] ins_target = '0;
    logic [DW-1:0] mem_data = '0;
    logic          mem_fault = 1'b0;
    logic [2:0]    view_sel = '0;
    logic [DW-1:0] view_data;
    logic          view_poison, redirect_valid, trap_valid;
    logic [TW-1:0] redirect_target;

    always #2 clk = ~clk;

    dfd_core u0 (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
        .ins_spec(ins_spec), .ins_rd(ins_rd), .ins_rs1(ins_rs1), .ins_rs2(ins_rs2),
        .ins_imm(ins_imm), .ins_target(ins_target), .mem_data(mem_data),
        .mem_fault(mem_fault), .view_sel(view_sel), .view_data(view_data),
        .view_poison(view_poison), .redirect_valid(redirect_valid),
        .redirect_target(redirect_target), .trap_valid(trap_valid)
    );

    int tests = 0, fails = 0;
    bit done = 1'b0;
    logic [DW-1:0] m_dat [NR];
    logic          m_poi [NR];
    logic          e_redir, e_trap;
    logic [TW-1:0] e_tgt;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        chk(req, "redirect_valid", {31'd0, redirect_valid}, {31'd0, e_redir});
        chk(req, "redirect_target", {16'd0, redirect_target}, {16'd0, e_tgt});
        chk(req, "trap_valid", {31'd0, trap_valid}, {31'd0, e_trap});
        for (int i = 0; i < NR; i++) begin
            view_sel = i[2:0];
            #0.1;
            chk(req, $sformatf("r%0d data", i), {16'd0, view_data}, {16'd0, m_dat[i]});
            chk(req, $sformatf("r%0d marker", i), {31'd0, view_poison}, {31'd0, m_poi[i]});
        end
    endtask

    task automatic step(input logic [2:0] op, input int rd, input int rs1, input int rs2,
                        input logic [DW-1:0] imm, input logic spec, input logic fault,
                        input logic [DW-1:0] md, input logic [TW-1:0] tgt);
        string tag;
        logic [DW-1:0] d1, d2, wv;
        logic p1, p2, wr, wp;
        d1 = m_dat[rs1]; p1 = m_poi[rs1];
        d2 = m_dat[rs2]; p2 = m_poi[rs2];
        wr = 1'b0; wp = 1'b0; wv = '0;
        e_redir = 1'b0; e_tgt = '0; e_trap = 1'b0;
        tag = "R2";
        case (op)
            3'd1, 3'd2, 3'd3, 3'd4: begin
                wr = 1'b1; wp = p1 | p2;
                wv = (op == 3'd1) ? d1 + d2 : (op == 3'd2) ? d1 - d2 :
                     (op == 3'd3) ? (d1 & d2) : (d1 ^ d2);
                tag = wp ? "R5" : "R2";
            end
            3'd5: begin
                tag = "R3";
                if (fault) begin
                    if (spec) begin wr = 1'b1; wp = 1'b1; end
                    else begin e_trap = 1'b1; tag = "R4"; end
                end else begin
                    wr = 1'b1; wv = md;
                end
            end
            3'd6: begin
                if (p1) begin e_redir = 1'b1; e_tgt = tgt; tag = "R6"; end
                else tag = "R7";
            end
            3'd7: begin wr = 1'b1; wv = imm; end
            default: ;
        endcase
        if (rd == 0 && (wr || op == 3'd6)) tag = "R8";
        ins_valid = 1'b1; ins_op = op; ins_rd = rd[2:0]; ins_rs1 = rs1[2:0];
        ins_rs2 = rs2[2:0]; ins_imm = imm; ins_spec = spec; mem_fault = fault;
        mem_data = md; ins_target = tgt;
        @(posedge clk);
        #1;
        ins_valid = 1'b0;
        if (wr && rd != 0) begin
            m_dat[rd] = wp ? '0 : wv;
            m_poi[rd] = wp;
        end
        compare_all(tag);
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin m_dat[i] = '0; m_poi[i] = 1'b0; end
        e_redir = 1'b0; e_trap = 1'b0; e_tgt = '0;
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1");
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        compare_all("R1");

        // R2: clean values and arithmetic
        step(3'd7, 1, 0, 0, 16'h1234, 0, 0, 0, 0);
        step(3'd7, 2, 0, 0, 16'hF00F, 0, 0, 0, 0);
        step(3'd1, 6, 1, 2, 0, 0, 0, 0, 0);
        step(3'd2, 7, 1, 2, 0, 0, 0, 0, 0);
        step(3'd3, 6, 6, 2, 0, 0, 0, 0, 0);
        step(3'd4, 7, 7, 1, 0, 0, 0, 0, 0);
        // R3: speculative faulting load taints r3, silently
        step(3'd5, 3, 0, 0, 0, 1, 1, 16'hDEAD, 0);
        // R5: taint flows through a dependent chain with no redirect
        step(3'd1, 4, 3, 1, 0, 0, 0, 0, 0);
        step(3'd4, 5, 2, 4, 0, 0, 0, 0, 0);
        // R7: clean check silent
        step(3'd6, 0, 1, 0, 0, 0, 0, 0, 16'hAAAA);
        // R6: tainted check redirects, then back-to-back checks
        step(3'd6, 0, 5, 0, 0, 0, 0, 0, 16'h4C00);
        step(3'd6, 0, 3, 0, 0, 0, 0, 0, 16'h4C40);
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2: a clean write clears the marker
        step(3'd7, 5, 0, 0, 16'h0077, 0, 0, 0, 0);
        step(3'd6, 0, 5, 0, 0, 0, 0, 0, 16'h1111);
        // R4: non-speculative fault traps and leaves r2 alone
        step(3'd5, 2, 0, 0, 0, 0, 1, 16'hBEEF, 0);
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3: non-faulting loads, both flavours, clean
        step(3'd5, 4, 0, 0, 0, 0, 0, 16'h5A5A, 0);
        step(3'd5, 3, 0, 0, 0, 1, 0, 16'hC3C3, 0);
        // R8: register zero ignores writes and taint
        step(3'd7, 0, 0, 0, 16'hFFFF, 0, 0, 0, 0);
        step(3'd5, 0, 0, 0, 0, 1, 1, 0, 0);
        step(3'd6, 0, 0, 0, 0, 0, 0, 0, 16'h9999);
        step(3'd1, 6, 0, 4, 0, 0, 0, 0, 0);

        // mixed pseudo-random stream
        begin
            logic [15:0] lf;
            lf = 16'hACE1;
            for (int n = 0; n < 300; n++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[2:0], int'(lf[5:3]), int'(lf[8:6]), int'(lf[11:9]),
                     {lf[7:0], lf[15:8]}, lf[12], lf[13] & lf[14],
                     lf ^ 16'h3C3C, {lf[3:0], lf[15:4]});
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule